// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block draws one small cursor on top of a display pixel stream that already carries video mixed with graphics. The cursor image is a store of 1024 two-bit codes. Software reshapes that store into one of five rectangles of equal area and places the rectangle anywhere on the screen, including partly past the right or bottom edge. Each code picks one of four palette entries. An entry holds a reduced-precision YUV colour and a two-bit transparency that sets one of four blend strengths.

Software writes the palette, the shape and the staged position through a small register port, and writes the image through a separate bitmap port. The staged position takes effect on the next field-start strobe, so the cursor never tears in the middle of a field. Each incoming pixel carries its horizontal and vertical counters. The blended pixel leaves the block one clock later.

Top module: `cursor_overlay`

## Requirements
- R1: After a synchronous active-low reset, out_valid is low, every palette entry has transparency 0 and both positions are 0, so valid pixels leave unchanged.
- R2: Each input pixel produces exactly one output pixel one clock later: out_valid is in_valid delayed by one cycle.
- R3: Shape code s (reg_addr 2, bits [2:0]) for s in 0..4 gives width 2^(3+s) and height 1024/width. Codes 5..7 act as code 2 (32x32). The pixel at cursor row r and column c is read from bitmap address r*width + c.
- R4: A palette entry k (reg_addr 4+k) packs Y in bits [15:10], U in [9:6], V in [5:2] and transparency T in [1:0]. reg_addr 0 and 1 write the staged X and Y position in bits [11:0].
- R5: The palette colour is widened to 8 bits per component by repeating its top bits below itself: a 6-bit Y becomes {Y, Y[5:4]} and a 4-bit U or V becomes {U, U}.
- R6: For a covered pixel with transparency T, each output component is: the input when T=0; (3*in + cursor)/4 rounded down when T=1; (in + cursor)/2 rounded down when T=2; the cursor colour when T=3.
- R7: A write to the staged position has no effect on the cursor until a field_start strobe. The copy made on that strobe is visible from the following cycle. A write made in the same cycle as the strobe waits for the next strobe.
- R8: A pixel whose counters lie outside the active area (hcnt >= 720 or vcnt >= 576 by default) is never covered, even if it lies inside the cursor rectangle.
- R9: Pixels outside the cursor rectangle (left of X, right of X+width-1, above Y or below Y+height-1) leave unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 X, 1 Y, 2 shape, 4..7 palette |
| reg_wdata | input | 16 | Register write data |
| bmp_we | input | 1 | Bitmap write strobe |
| bmp_addr | input | 10 | Bitmap address (row*width + column) |
| bmp_wdata | input | 2 | Bitmap pixel code |
| field_start | input | 1 | Field-start strobe, loads the staged position |
| in_valid | input | 1 | Input pixel valid |
| in_hcnt | input | 12 | Horizontal counter of the input pixel |
| in_vcnt | input | 12 | Vertical counter of the input pixel |
| in_y | input | 8 | Input luma |
| in_u | input | 8 | Input U chroma |
| in_v | input | 8 | Input V chroma |
| out_valid | output | 1 | Output pixel valid |
| out_y | output | 8 | Blended luma |
| out_u | output | 8 | Blended U chroma |
| out_v | output | 8 | Blended V chroma |

## Verification
Two functions can fall in the same cycle: a staged-position write and a field-start strobe. The bench drives both together. It then checks that pixels at the old staged location show the cursor while the newly written location stays clear until a second strobe. The second overlap is at the screen edge, where the active-area clip cuts through a cursor that lies partly off screen. Pixels on both sides of column 720 and row 576 are compared against a model of the rectangle and the clip.

// File: rtl/cursor_pkg.sv
// Package: shared types and helpers for the cursor overlay.
// Assumes a 1024-entry bitmap and power-of-two cursor widths.
package cursor_pkg;
    localparam int BMP_PIXELS  = 1024;
    localparam int BMP_AW      = $clog2(BMP_PIXELS);
    localparam int PAL_N       = 4;
    localparam int SHAPE_COUNT = 5;
    localparam int MIN_W_LOG2  = 3;
    localparam int DEF_SHAPE   = 2;

    typedef struct packed {
        logic [5:0] y;
        logic [3:0] u;
        logic [3:0] v;
        logic [1:0] t;
    } pal_entry_t;

    // Widen a 6-bit component by repeating its top bits.
    function automatic logic [7:0] widen6(input logic [5:0] c);
        return {c, c[5:4]};
    endfunction

    // Widen a 4-bit component by repeating it.
    function automatic logic [7:0] widen4(input logic [3:0] c);
        return {c, c};
    endfunction

    // Mix base and cursor components at one of four strengths.
    function automatic logic [7:0] mix(input logic [1:0] lvl,
                                       input logic [7:0] base,
                                       input logic [7:0] curs);
        logic [9:0] quarter;
        logic [8:0] half;
        quarter = {2'b00, base} + {1'b0, base, 1'b0} + {2'b00, curs};
        half    = {1'b0, base} + {1'b0, curs};
        case (lvl)
            2'd0:    return base;
            2'd1:    return quarter[9:2];
            2'd2:    return half[8:1];
            default: return curs;
        endcase
    endfunction
endpackage

// File: rtl/cursor_regs.sv
// Module: cursor_regs
// Holds the staged and active cursor position, the shape code and the
// palette. The staged position is copied to the active one on field_start.
// Assumes RDW >= 16 and RDW >= HCW.
module cursor_regs
    import cursor_pkg::*;
#(
    parameter int HCW = 12,
    parameter int RDW = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [2:0]                  reg_addr,
    input  logic [RDW-1:0]              reg_wdata,
    input  logic                        field_start,
    output logic [HCW-1:0]              act_x,
    output logic [HCW-1:0]              act_y,
    output logic [2:0]                  shape,
    output pal_entry_t [PAL_N-1:0]      pal
);
    logic [HCW-1:0] stg_x;
    logic [HCW-1:0] stg_y;

    // Software writes: staged position, shape, palette entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_x <= '0;
            stg_y <= '0;
            shape <= '0;
            pal   <= '0;
        end else if (reg_we) begin
            if (reg_addr[2]) begin
                pal[reg_addr[1:0]] <= pal_entry_t'(reg_wdata[15:0]);
            end else begin
                case (reg_addr[1:0])
                    2'd0:    stg_x <= reg_wdata[HCW-1:0];
                    2'd1:    stg_y <= reg_wdata[HCW-1:0];
                    2'd2:    shape <= reg_wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    // Field-boundary copy of the staged position into the active one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_x <= '0;
            act_y <= '0;
        end else if (field_start) begin
            act_x <= stg_x;
            act_y <= stg_y;
        end
    end

    // R7
    act_pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> ($stable(act_x) && $stable(act_y)));
endmodule

// File: rtl/cursor_bitmap.sv
// Module: cursor_bitmap
// Flop store of the cursor image, one code per pixel, with a
// combinational read port. Assumes one write per cycle at most.
module cursor_bitmap
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BMP_AW-1:0] wr_addr,
    input  logic [1:0]        wr_code,
    input  logic [BMP_AW-1:0] rd_addr,
    output logic [1:0]        rd_code
);
    logic [1:0] store [BMP_PIXELS];

    // Image write port.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_code;
    end

    // Combinational read for the current pixel.
    always_comb rd_code = store[rd_addr];
endmodule

// File: rtl/cursor_hit.sv
// Module: cursor_hit
// Decides whether the current pixel lies inside the cursor rectangle and
// inside the active area, and forms the bitmap address row*width+column.
// Assumes HCW >= BMP_AW and that widths are powers of two.
module cursor_hit
    import cursor_pkg::*;
#(
    parameter int HCW   = 12,
    parameter int ACT_W = 720,
    parameter int ACT_H = 576
) (
    input  logic [HCW-1:0]    hcnt,
    input  logic [HCW-1:0]    vcnt,
    input  logic [HCW-1:0]    pos_x,
    input  logic [HCW-1:0]    pos_y,
    input  logic [2:0]        shape,
    output logic              hit,
    output logic [BMP_AW-1:0] addr
);
    localparam logic [HCW-1:0] ACT_W_L = HCW'(ACT_W);
    localparam logic [HCW-1:0] ACT_H_L = HCW'(ACT_H);
    localparam logic [2:0]     SHP_N_L = 3'(SHAPE_COUNT);
    localparam logic [2:0]     SHP_D_L = 3'(DEF_SHAPE);
    localparam logic [2:0]     MINW_L  = 3'(MIN_W_LOG2);
    localparam logic [3:0]     AW_L    = 4'(BMP_AW);

    logic [2:0]     w_log2;
    logic [3:0]     h_log2;
    logic [HCW-1:0] dx;
    logic [HCW-1:0] dy;
    logic [HCW-1:0] lin;
    logic           in_cols;
    logic           in_rows;
    logic           on_screen;

    // Shape decode: width and height exponents, reserved codes fold to default.
    always_comb begin
        w_log2 = (shape < SHP_N_L) ? shape + MINW_L : SHP_D_L + MINW_L;
        h_log2 = AW_L - {1'b0, w_log2};
    end

    // Rectangle test, active-area clip and linear address.
    always_comb begin
        dx        = hcnt - pos_x;
        dy        = vcnt - pos_y;
        in_cols   = (hcnt >= pos_x) && ((dx >> w_log2) == '0);
        in_rows   = (vcnt >= pos_y) && ((dy >> h_log2) == '0);
        on_screen = (hcnt < ACT_W_L) && (vcnt < ACT_H_L);
        hit       = in_cols && in_rows && on_screen;
        lin       = (dy << w_log2) | dx;
        addr      = lin[BMP_AW-1:0];
    end
endmodule

// File: rtl/cursor_blend.sv
// Module: cursor_blend
// Widens the selected palette colour and mixes it over the input pixel,
// registering the result. Assumes hit and code belong to the same pixel.
module cursor_blend
    import cursor_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_y,
    input  logic [7:0]             in_u,
    input  logic [7:0]             in_v,
    input  logic                   hit,
    input  logic [1:0]             code,
    input  pal_entry_t [PAL_N-1:0] pal,
    output logic                   out_valid,
    output logic [7:0]             out_y,
    output logic [7:0]             out_u,
    output logic [7:0]             out_v
);
    pal_entry_t sel;
    logic [1:0] lvl;

    // Palette pick and effective strength (zero when not covered).
    always_comb begin
        sel = pal[code];
        lvl = hit ? sel.t : 2'd0;
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_y     <= '0;
            out_u     <= '0;
            out_v     <= '0;
        end else begin
            out_valid <= in_valid;
            out_y     <= mix(lvl, in_y, widen6(sel.y));
            out_u     <= mix(lvl, in_u, widen4(sel.u));
            out_v     <= mix(lvl, in_v, widen4(sel.v));
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R6
    clear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!hit || sel.t == 2'd0)) |=>
        (out_y == $past(in_y) && out_u == $past(in_u) && out_v == $past(in_v)));
    // R5
    solid_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit && sel.t == 2'd3) |=>
        (out_u[7:4] == $past(sel.u) && out_u[3:0] == $past(sel.u) &&
         out_y[7:2] == $past(sel.y)));
endmodule

// File: rtl/cursor_overlay.sv
// Module: cursor_overlay (top)
// Single hardware cursor blended over a pixel stream with one cycle of
// latency. Assumes the stream supplies counters with each pixel and a
// field_start strobe in a cycle of its own choosing.
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int HCW   = 12,
    parameter int RDW   = 16,
    parameter int ACT_W = 720,
    parameter int ACT_H = 576
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [RDW-1:0]  reg_wdata,
    input  logic            bmp_we,
    input  logic [9:0]      bmp_addr,
    input  logic [1:0]      bmp_wdata,
    input  logic            field_start,
    input  logic            in_valid,
    input  logic [HCW-1:0]  in_hcnt,
    input  logic [HCW-1:0]  in_vcnt,
    input  logic [7:0]      in_y,
    input  logic [7:0]      in_u,
    input  logic [7:0]      in_v,
    output logic            out_valid,
    output logic [7:0]      out_y,
    output logic [7:0]      out_u,
    output logic [7:0]      out_v
);
    logic [HCW-1:0]         act_x;
    logic [HCW-1:0]         act_y;
    logic [2:0]             shape;
    pal_entry_t [PAL_N-1:0] pal;
    logic                   hit;
    logic [BMP_AW-1:0]      rd_addr;
    logic [1:0]             code;

    cursor_regs #(.HCW(HCW), .RDW(RDW)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .field_start(field_start),
        .act_x(act_x), .act_y(act_y), .shape(shape), .pal(pal));

    cursor_bitmap u_bmp (
        .clk(clk), .wr_en(bmp_we), .wr_addr(bmp_addr), .wr_code(bmp_wdata),
        .rd_addr(rd_addr), .rd_code(code));

    cursor_hit #(.HCW(HCW), .ACT_W(ACT_W), .ACT_H(ACT_H)) u_hit (
        .hcnt(in_hcnt), .vcnt(in_vcnt), .pos_x(act_x), .pos_y(act_y),
        .shape(shape), .hit(hit), .addr(rd_addr));

    cursor_blend u_blend (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y),
        .in_u(in_u), .in_v(in_v), .hit(hit), .code(code), .pal(pal),
        .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v));

    // R8
    clip_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (in_hcnt < HCW'(ACT_W) && in_vcnt < HCW'(ACT_H)));
    // R9
    rect_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (in_hcnt >= act_x && in_vcnt >= act_y));
endmodule

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        bmp_we = 1'b0;
    logic [9:0]  bmp_addr = '0;
    logic [1:0]  bmp_wdata = '0;
    logic        field_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_hcnt = '0;
    logic [11:0] in_vcnt = '0;
    logic [7:0]  in_y = '0;
    logic [7:0]  in_u = '0;
    logic [7:0]  in_v = '0;
    logic        out_valid;
    logic [7:0]  out_y;
    logic [7:0]  out_u;
    logic [7:0]  out_v;

    always #2 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .bmp_we(bmp_we), .bmp_addr(bmp_addr),
        .bmp_wdata(bmp_wdata), .field_start(field_start), .in_valid(in_valid),
        .in_hcnt(in_hcnt), .in_vcnt(in_vcnt), .in_y(in_y), .in_u(in_u),
        .in_v(in_v), .out_valid(out_valid), .out_y(out_y), .out_u(out_u),
        .out_v(out_v));

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [23:0] exp_q[$];
    string       tag_q[$];

    // Reference state kept from the requirements.
    logic [1:0]  m_bmp [1024];
    logic [15:0] m_pal [4];
    int          m_shape = 0;
    int          m_sx = 0, m_sy = 0, m_ax = 0, m_ay = 0;

    function automatic logic [7:0] m_mix(int t, logic [7:0] b, logic [7:0] c);
        int r;
        case (t)
            0: r = b;
            1: r = (3 * b + c) / 4;
            2: r = (b + c) / 2;
            default: r = c;
        endcase
        return r[7:0];
    endfunction

    function automatic logic [23:0] predict(int h, int v, logic [7:0] y, logic [7:0] u, logic [7:0] vv);
        int lw, w, ht, t;
        logic [1:0]  c;
        logic [15:0] e;
        logic [7:0]  cy, cu, cv;
        lw = (m_shape < 5) ? m_shape + 3 : 5;
        w  = 1 << lw;
        ht = 1024 / w;
        if (h < 720 && v < 576 && h >= m_ax && h < m_ax + w && v >= m_ay && v < m_ay + ht) begin
            c  = m_bmp[(v - m_ay) * w + (h - m_ax)];
            e  = m_pal[c];
            t  = int'(e[1:0]);
            cy = {e[15:10], e[15:14]};
            cu = {e[9:6], e[9:6]};
            cv = {e[5:2], e[5:2]};
            return {m_mix(t, y, cy), m_mix(t, u, cu), m_mix(t, vv, cv)};
        end
        return {y, u, vv};
    endfunction

    task automatic clear_in();
        reg_we = 1'b0; bmp_we = 1'b0; field_start = 1'b0; in_valid = 1'b0;
    endtask

    task automatic wr_reg(int a, logic [15:0] d, bit with_sof);
        @(negedge clk);
        clear_in();
        reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = d;
        field_start = with_sof;
        if (with_sof) begin m_ax = m_sx; m_ay = m_sy; end
        case (a)
            0: m_sx = int'(d[11:0]);
            1: m_sy = int'(d[11:0]);
            2: m_shape = int'(d[2:0]);
            4, 5, 6, 7: m_pal[a - 4] = d;
            default: ;
        endcase
    endtask

    task automatic new_field();
        @(negedge clk);
        clear_in();
        field_start = 1'b1;
        m_ax = m_sx; m_ay = m_sy;
    endtask

    task automatic idle();
        @(negedge clk);
        clear_in();
    endtask

    // Driver: one pixel, expected result pushed to the scoreboard.
    task automatic pix(int h, int v, logic [7:0] y, logic [7:0] u, logic [7:0] vv, string tag);
        @(negedge clk);
        clear_in();
        in_valid = 1'b1; in_hcnt = h[11:0]; in_vcnt = v[11:0];
        in_y = y; in_u = u; in_v = vv;
        exp_q.push_back(predict(h, v, y, u, vv));
        tag_q.push_back(tag);
    endtask

    task automatic check_bit(logic got, logic want, string tag);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: out_valid got %0b expected %0b", tag, got, want);
        end
    endtask

    // Monitor: pops the scoreboard whenever an output pixel appears.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected output %h, expected none", {out_y, out_u, out_v});
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_y, out_u, out_v} !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", t, {out_y, out_u, out_v}, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c3;
        for (int a = 0; a < 1024; a++) m_bmp[a] = 2'(a ^ (a >> 3) ^ (a >> 6));
        for (int k = 0; k < 4; k++) m_pal[k] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_bit(out_valid, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        for (int a = 0; a < 1024; a++) begin
            @(negedge clk);
            clear_in();
            bmp_we = 1'b1; bmp_addr = a[9:0]; bmp_wdata = m_bmp[a];
        end

        // R1: default palette is clear, cursor at origin shows nothing
        for (int i = 0; i < 6; i++) pix(i, i, 8'(20 + i), 8'(90 + i), 8'(200 - i), "R1");
        idle();
        idle();
        // R2: idle gap gives no output
        check_bit(out_valid, 1'b0, "R2");

        // R4: palette and position programming
        wr_reg(4, {6'h3F, 4'h1, 4'h2, 2'd0}, 1'b0);
        wr_reg(5, {6'h2D, 4'hA, 4'h5, 2'd1}, 1'b0);
        wr_reg(6, {6'h10, 4'hF, 4'h0, 2'd2}, 1'b0);
        wr_reg(7, {6'h2D, 4'hA, 4'h5, 2'd3}, 1'b0);
        wr_reg(2, 16'd2, 1'b0);
        wr_reg(0, 16'd100, 1'b0);
        wr_reg(1, 16'd50, 1'b0);
        new_field();

        // R3 R6 R9: edges and interior of a 32x32 cursor
        foreach (tag_q[i]) ;
        for (int r = -1; r <= 32; r++) begin
            for (int c = -1; c <= 32; c += 3) begin
                pix(100 + c, 50 + r, 8'(r * 7 + c), 8'(200 - r), 8'(c * 5), "R6");
            end
        end
        // R6: a full row with back-to-back pixels
        for (int c = 0; c < 32; c++) pix(100 + c, 61, 8'hF0, 8'h0F, 8'h80, "R6");
        // R9: just outside each side
        pix(99, 60, 8'h11, 8'h22, 8'h33, "R9");
        pix(132, 60, 8'h11, 8'h22, 8'h33, "R9");
        pix(110, 49, 8'h11, 8'h22, 8'h33, "R9");
        pix(110, 82, 8'h11, 8'h22, 8'h33, "R9");

        // R5: pixel whose code is 3, full replacement with widened colour
        c3 = 0;
        for (int a = 1023; a >= 0; a--) if (m_bmp[a] == 2'd3) c3 = a;
        pix(100 + c3 % 32, 50 + c3 / 32, 8'h00, 8'hFF, 8'h00, "R5");
        idle();
        checks++;
        if ({out_y, out_u, out_v} !== {8'hB6, 8'hAA, 8'h55}) begin
            errors++;
            $display("FAIL R5: got %h expected %h", {out_y, out_u, out_v}, {8'hB6, 8'hAA, 8'h55});
        end

        // R7: staged position has no effect before the strobe
        wr_reg(0, 16'd300, 1'b0);
        wr_reg(1, 16'd200, 1'b0);
        for (int i = 0; i < 8; i++) pix(300 + i, 200 + i, 8'h40, 8'h50, 8'h60, "R7");
        for (int i = 0; i < 8; i++) pix(100 + i, 50 + i, 8'h40, 8'h50, 8'h60, "R7");
        new_field();
        for (int i = 0; i < 8; i++) pix(300 + i, 200 + i, 8'h40, 8'h50, 8'h60, "R7");
        for (int i = 0; i < 8; i++) pix(100 + i, 50 + i, 8'h40, 8'h50, 8'h60, "R7");
        // R7: write coinciding with the strobe waits for the next one
        wr_reg(0, 16'd400, 1'b1);
        for (int i = 0; i < 8; i++) pix(300 + i, 200 + i, 8'h41, 8'h51, 8'h61, "R7");
        for (int i = 0; i < 8; i++) pix(400 + i, 200 + i, 8'h41, 8'h51, 8'h61, "R7");
        new_field();
        for (int i = 0; i < 8; i++) pix(400 + i, 200 + i, 8'h42, 8'h52, 8'h62, "R7");
        wr_reg(0, 16'd300, 1'b0);
        new_field();

        // R3: every shape code including a reserved one
        for (int s = 0; s < 8; s++) begin
            int w, ht;
            if (s == 5 || s == 7) continue;
            wr_reg(2, 16'(s), 1'b0);
            w  = (s < 5) ? (8 << s) : 32;
            ht = 1024 / w;
            pix(300 + w - 1, 200 + ht - 1, 8'h70, 8'h30, 8'h90, "R3");
            pix(300 + w - 2, 200 + 1, 8'h70, 8'h30, 8'h90, "R3");
            pix(300 + w, 200, 8'h70, 8'h30, 8'h90, "R3");
            pix(300, 200 + ht, 8'h70, 8'h30, 8'h90, "R3");
            pix(300 + w / 2, 200 + ht / 2, 8'h70, 8'h30, 8'h90, "R3");
        end

        // R8: cursor partly past the active area
        wr_reg(2, 16'd2, 1'b0);
        wr_reg(0, 16'd705, 1'b0);
        wr_reg(1, 16'd565, 1'b0);
        new_field();
        for (int h = 700; h < 740; h += 2) pix(h, 570, 8'h55, 8'h66, 8'h77, "R8");
        for (int v = 570; v < 600; v += 2) pix(712, v, 8'h55, 8'h66, 8'h77, "R8");
        pix(719, 575, 8'h01, 8'h02, 8'h03, "R8");
        pix(720, 575, 8'h01, 8'h02, 8'h03, "R8");
        pix(719, 576, 8'h01, 8'h02, 8'h03, "R8");

        // R9: cursor at the origin
        wr_reg(0, 16'd0, 1'b0);
        wr_reg(1, 16'd0, 1'b0);
        new_field();
        for (int i = 0; i < 34; i += 3) pix(i, i, 8'h9A, 8'hBC, 8'hDE, "R9");

        idle();
        idle();
        idle();
        if (exp_q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R2: got %0d missing outputs expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule